// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Sequencer

This block computes C = M^e mod N. It reads the exponent from its least significant bit upward and does no multiplication of its own. Every product goes to an external Montgomery multiplier through a request/response port. The sequencer sends an operand pair and holds it until the multiplier accepts it. It then waits for a result-valid pulse and writes the product into its own registers.

The host supplies the base, the exponent, the exponent length h, an odd modulus and the constant R^2 mod N, where R = 2^WIDTH. The sequencer first brings the base and the value one into the Montgomery domain by multiplying each by that constant. It then runs the loop. On every exponent bit below the top one, it issues C×P when the bit is one and always issues P×P. Both products of an iteration use the old P. The conditional product goes first and is parked in a holding register. Both values are committed when the square returns. The top bit gets one more conditional C×P and no square. A final multiply by the literal 1 takes the result out of the Montgomery domain. The result then appears with a one-cycle done pulse.

Top module: `modexp_seq`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `done` is 0, `mulValid` is 0 and `result` is 0.
- R2: After a start, `result` equals M^e mod N, where e is formed from exponent bits [h-1:0] only. Exponent bits at index h and above have no effect. The base must be below N, and N must be odd and greater than 1.
- R3: For h ≥ 1, one operation issues exactly 3 + (h-1) + popcount(e[h-1:0]) multiplier requests. For h = 0 it issues exactly 3.
- R4: The first request carries operands (M, R^2 mod N). The second carries (1, R^2 mod N). The last carries operand B equal to 1. Every request presents N on the modulus port.
- R5: Once `mulValid` is high, the operands stay stable and `mulValid` stays high until a cycle in which `mulReady` is high.
- R6: At most one request is outstanding. No new request is accepted until the result-valid pulse of the previous one has arrived.
- R7: With h = 0 the result is 1. With h = 1 the result is M when bit 0 is one and 1 when it is zero.
- R8: A start pulse that arrives while an operation is in progress is ignored, and the running operation's result is unchanged.
- R9: `done` is high for exactly one cycle per operation, in the cycle `result` first shows the new value. `result` then holds until a later operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base | input | WIDTH | Base M, below the modulus |
| exponent | input | EXP_W | Exponent bits, bit 0 processed first |
| expLen | input | HW | Exponent length h, 0 to EXP_W |
| modulus | input | WIDTH | Odd modulus N |
| convConst | input | WIDTH | R^2 mod N, R = 2^WIDTH |
| mulValid | output | 1 | Operand pair offered to the multiplier |
| mulReady | input | 1 | Multiplier accepts the pair this cycle |
| mulOpA | output | WIDTH | Multiplier operand A |
| mulOpB | output | WIDTH | Multiplier operand B |
| mulMod | output | WIDTH | Modulus for the multiplier |
| mulResValid | input | 1 | One-cycle pulse, product present |
| mulResult | input | WIDTH | Montgomery product A·B·R^-1 mod N |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Final M^e mod N, held |

## Verification
The exponent patterns are chosen so that each one isolates a part of the logic. All-zero bits exercise the path with no conditional products. All-one bits put a conditional product in front of every square. Set bits above h show whether the length counter or the raw exponent ends the loop. The lengths 0 and 1 test the branches that skip the loop entirely. Random bases, moduli and exponents run under random multiplier latency and random ready stalls. Any error in the order of the two products within an iteration, or in when they are committed, then shows up as a wrong result or a wrong request count. A start pulse injected mid-run checks that the operation in flight is not disturbed.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  // Operand pair chosen for the multiplier request.
  typedef enum logic [2:0] {
    OP_BASE_CONV = 3'd0,   // (M, R^2)
    OP_ONE_CONV  = 3'd1,   // (1, R^2)
    OP_C_P       = 3'd2,   // (C, P)
    OP_P_P       = 3'd3,   // (P, P)
    OP_C_ONE     = 3'd4    // (C, 1)
  } opSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic   ldIn;       // capture host inputs
    opSel_e opSel;      // operand mux
    logic   capP;       // P <= product
    logic   capC;       // C <= product
    logic   capHold;    // holding register <= product
    logic   commitHold; // C <= holding register
    logic   shiftExp;   // advance to next exponent bit
    logic   capRes;     // result <= product
  } ctrlStrobe_t;

endpackage

// File: rtl/modexp_dp.sv
module modexp_dp
  import modexp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int EXP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctl,
  input  logic [WIDTH-1:0]  base,
  input  logic [EXP_W-1:0]  exponent,
  input  logic [WIDTH-1:0]  modulus,
  input  logic [WIDTH-1:0]  convConst,
  input  logic [WIDTH-1:0]  mulResult,
  output logic [WIDTH-1:0]  mulOpA,
  output logic [WIDTH-1:0]  mulOpB,
  output logic [WIDTH-1:0]  mulMod,
  output logic              expBit,
  output logic [WIDTH-1:0]  result
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] baseReg, modReg, convReg;
  logic [EXP_W-1:0] expReg;
  logic [WIDTH-1:0] cReg, pReg, holdReg, resReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      modReg  <= '0;
      convReg <= '0;
      expReg  <= '0;
      cReg    <= '0;
      pReg    <= '0;
      holdReg <= '0;
      resReg  <= '0;
    end else begin
      if (ctl.ldIn) begin
        baseReg <= base;
        modReg  <= modulus;
        convReg <= convConst;
        expReg  <= exponent;
      end
      if (ctl.shiftExp) expReg <= expReg >> 1;
      if (ctl.capP)     pReg    <= mulResult;
      if (ctl.capHold)  holdReg <= mulResult;
      if (ctl.capC)            cReg <= mulResult;
      else if (ctl.commitHold) cReg <= holdReg;
      if (ctl.capRes)   resReg  <= mulResult;
    end
  end

  always_comb begin
    unique case (ctl.opSel)
      OP_BASE_CONV: begin mulOpA = baseReg; mulOpB = convReg; end
      OP_ONE_CONV:  begin mulOpA = ONE;     mulOpB = convReg; end
      OP_C_P:       begin mulOpA = cReg;    mulOpB = pReg;    end
      OP_P_P:       begin mulOpA = pReg;    mulOpB = pReg;    end
      OP_C_ONE:     begin mulOpA = cReg;    mulOpB = ONE;     end
      default:      begin mulOpA = '0;      mulOpB = '0;      end
    endcase
  end

  assign mulMod = modReg;
  assign expBit = expReg[0];
  assign result = resReg;

endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int EXP_W = 16,
  parameter int HW    = $clog2(EXP_W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [HW-1:0] expLen,
  input  logic          expBit,
  input  logic          mulReady,
  input  logic          mulResValid,
  output ctrlStrobe_t   ctl,
  output logic          mulValid,
  output logic          done
);

  typedef enum logic [3:0] {
    S_IDLE, S_CONVM, S_CONVONE, S_ITER, S_MULC, S_SQP, S_LAST, S_EXIT, S_DONE
  } state_e;

  state_e state, nextState;
  logic          issued;
  logic [HW-1:0] remaining;
  logic          isMul, resHit;

  always_comb begin
    unique case (state)
      S_CONVM, S_CONVONE, S_MULC, S_SQP, S_LAST, S_EXIT: isMul = 1'b1;
      default:                                             isMul = 1'b0;
    endcase
  end

  assign resHit   = isMul && issued && mulResValid;
  assign mulValid = isMul && !issued;
  assign done     = (state == S_DONE);

  always_comb begin
    ctl       = '0;
    ctl.opSel = OP_BASE_CONV;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.ldIn  = 1'b1;
          nextState = S_CONVM;
        end
      end
      S_CONVM: begin
        ctl.opSel = OP_BASE_CONV;
        if (resHit) begin
          ctl.capP  = 1'b1;
          nextState = S_CONVONE;
        end
      end
      S_CONVONE: begin
        ctl.opSel = OP_ONE_CONV;
        if (resHit) begin
          ctl.capC  = 1'b1;
          nextState = S_ITER;
        end
      end
      S_ITER: begin
        if (remaining == '0)
          nextState = S_EXIT;
        else if (remaining == HW'(1))
          nextState = expBit ? S_LAST : S_EXIT;
        else
          nextState = expBit ? S_MULC : S_SQP;
      end
      S_MULC: begin
        ctl.opSel = OP_C_P;
        if (resHit) begin
          ctl.capHold = 1'b1;
          nextState   = S_SQP;
        end
      end
      S_SQP: begin
        ctl.opSel = OP_P_P;
        if (resHit) begin
          ctl.capP       = 1'b1;
          ctl.commitHold = expBit;
          ctl.shiftExp   = 1'b1;
          nextState      = S_ITER;
        end
      end
      S_LAST: begin
        ctl.opSel = OP_C_P;
        if (resHit) begin
          ctl.capC  = 1'b1;
          nextState = S_EXIT;
        end
      end
      S_EXIT: begin
        ctl.opSel = OP_C_ONE;
        if (resHit) begin
          ctl.capRes = 1'b1;
          nextState  = S_DONE;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      issued    <= 1'b0;
      remaining <= '0;
    end else begin
      state <= nextState;
      if (mulValid && mulReady) issued <= 1'b1;
      else if (resHit)          issued <= 1'b0;
      if (state == S_IDLE && start)
        remaining <= expLen;
      else if (state == S_SQP && resHit)
        remaining <= remaining - HW'(1);
    end
  end

endmodule

// File: rtl/modexp_seq.sv
module modexp_seq
  import modexp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int EXP_W = 16,
  parameter int HW    = $clog2(EXP_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] base,
  input  logic [EXP_W-1:0] exponent,
  input  logic [HW-1:0]    expLen,
  input  logic [WIDTH-1:0] modulus,
  input  logic [WIDTH-1:0] convConst,
  output logic             mulValid,
  input  logic             mulReady,
  output logic [WIDTH-1:0] mulOpA,
  output logic [WIDTH-1:0] mulOpB,
  output logic [WIDTH-1:0] mulMod,
  input  logic             mulResValid,
  input  logic [WIDTH-1:0] mulResult,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  ctrlStrobe_t ctl;
  logic        expBit;

  modexp_ctrl #(.EXP_W(EXP_W), .HW(HW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .expLen(expLen), .expBit(expBit),
    .mulReady(mulReady), .mulResValid(mulResValid),
    .ctl(ctl), .mulValid(mulValid), .done(done)
  );

  modexp_dp #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .base(base), .exponent(exponent),
    .modulus(modulus), .convConst(convConst), .mulResult(mulResult),
    .mulOpA(mulOpA), .mulOpB(mulOpB), .mulMod(mulMod), .expBit(expBit),
    .result(result)
  );

endmodule

// File: rtl/modexp_seq_chk.sv
module modexp_seq_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             mulValid,
  input logic             mulReady,
  input logic [WIDTH-1:0] mulOpA,
  input logic [WIDTH-1:0] mulOpB,
  input logic             mulResValid,
  input logic             done,
  input logic [WIDTH-1:0] result
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN)                       outstanding <= 1'b0;
    else if (mulValid && mulReady)   outstanding <= 1'b1;
    else if (mulResValid)            outstanding <= 1'b0;
  end

  // R5: request held stable until accepted
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (mulValid && !mulReady) |=> (mulValid && $stable(mulOpA) && $stable(mulOpB)));

  // R6: single outstanding request
  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (mulValid && mulReady) |-> !outstanding);

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: result only changes together with done
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R6: no request offered while completing
  a_r6_idle_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !mulValid);

endmodule

bind modexp_seq modexp_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .mulValid(mulValid), .mulReady(mulReady),
  .mulOpA(mulOpA), .mulOpB(mulOpB), .mulResValid(mulResValid),
  .done(done), .result(result)
);

// File: tb/modexp_seq_tb.sv
module modexp_seq_tb;

  localparam int WIDTH = 16;
  localparam int EXP_W = 16;
  localparam int HW    = $clog2(EXP_W + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] base = '0, modulus = 16'd3, convConst = '0;
  logic [EXP_W-1:0] exponent = '0;
  logic [HW-1:0]    expLen = '0;
  logic             mulValid, mulReady;
  logic [WIDTH-1:0] mulOpA, mulOpB, mulMod;
  logic             mulResValid;
  logic [WIDTH-1:0] mulResult;
  logic             done;
  logic [WIDTH-1:0] result;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  modexp_seq #(.WIDTH(WIDTH), .EXP_W(EXP_W), .HW(HW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .base(base), .exponent(exponent),
    .expLen(expLen), .modulus(modulus), .convConst(convConst),
    .mulValid(mulValid), .mulReady(mulReady), .mulOpA(mulOpA), .mulOpB(mulOpB),
    .mulMod(mulMod), .mulResValid(mulResValid), .mulResult(mulResult),
    .done(done), .result(result)
  );

  function automatic longint unsigned montMul(longint unsigned a, longint unsigned b,
                                              longint unsigned n);
    longint unsigned s = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (a[i]) s = s + b;
      if (s[0]) s = s + n;
      s = s >> 1;
    end
    if (s >= n) s = s - n;
    return s;
  endfunction

  function automatic longint unsigned modPow(longint unsigned m, longint unsigned e,
                                             int h, longint unsigned n);
    longint unsigned r = 1 % n;
    longint unsigned p = m % n;
    for (int i = 0; i < h; i++) begin
      if (e[i]) r = (r * p) % n;
      p = (p * p) % n;
    end
    return r;
  endfunction

  // Behavioural multiplier with random ready and latency
  int reqCount = 0;
  logic [WIDTH-1:0] req0A, req0B, req1A, req1B, lastB;
  logic modBad = 1'b0;
  logic busyM = 1'b0;
  int   lat = 0;
  logic [WIDTH-1:0] pend;

  always @(posedge clk) begin
    mulResValid <= 1'b0;
    if (!rstN) begin
      busyM    <= 1'b0;
      mulReady <= 1'b0;
      mulResult <= '0;
    end else begin
      if (busyM) begin
        if (lat == 0) begin
          mulResValid <= 1'b1;
          mulResult   <= pend;
          busyM       <= 1'b0;
        end else lat <= lat - 1;
      end else if (mulValid && mulReady) begin
        pend  <= WIDTH'(montMul(mulOpA, mulOpB, mulMod));
        lat   <= int'($urandom % 4);
        busyM <= 1'b1;
        if (reqCount == 0) begin req0A <= mulOpA; req0B <= mulOpB; end
        if (reqCount == 1) begin req1A <= mulOpA; req1B <= mulOpB; end
        lastB <= mulOpB;
        if (mulMod != modulus) modBad <= 1'b1;
        reqCount <= reqCount + 1;
      end
      mulReady <= ($urandom % 3) != 0;
    end
  end

  initial mulResValid = 1'b0;

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // Run one operation; optionally inject a second start mid-run.
  task automatic runOp(input longint unsigned m, input longint unsigned e, input int h,
                       input longint unsigned n, input bit inject, input string tag);
    longint unsigned expRes = modPow(m, e & ((64'd1 << h) - 1), h, n);
    longint unsigned r2 = (64'd1 << (2 * WIDTH)) % n;
    int expCnt = 3 + ((h > 0) ? (h - 1) : 0);
    int wait_n = 0;
    logic [WIDTH-1:0] held;
    for (int i = 0; i < h; i++) if (e[i]) expCnt++;
    @(negedge clk);
    base = WIDTH'(m); exponent = EXP_W'(e); expLen = HW'(h);
    modulus = WIDTH'(n); convConst = WIDTH'(r2);
    reqCount = 0; modBad = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (6) @(negedge clk);
      base = WIDTH'(n - 1); exponent = ~exponent; expLen = HW'(EXP_W);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done == 1'b1, {tag, " R9 done seen"}, done, 1);
    if (inject)
      check(result == WIDTH'(expRes), {tag, " R8 start ignored while busy"}, result, expRes);
    else if (h <= 1)
      check(result == WIDTH'(expRes), {tag, " R7 short exponent"}, result, expRes);
    else
      check(result == WIDTH'(expRes), {tag, " R2 result"}, result, expRes);
    check(reqCount == expCnt, {tag, " R3 request count"}, reqCount, expCnt);
    check(req0A == WIDTH'(m) && req0B == WIDTH'(r2), {tag, " R4 first request"}, req0A, m);
    check(req1A == WIDTH'(1) && req1B == WIDTH'(r2), {tag, " R4 second request"}, req1A, 1);
    check(lastB == WIDTH'(1) && !modBad, {tag, " R4 exit request"}, lastB, 1);
    held = result;
    @(negedge clk);
    check(done == 1'b0, {tag, " R9 single-cycle done"}, done, 0);
    repeat (3) @(negedge clk);
    check(result == held, {tag, " R9 result held"}, result, held);
  endtask

  initial begin
    longint unsigned n, m, e;
    int h;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    check(done == 1'b0 && mulValid == 1'b0 && result == '0, "R1 reset state", result, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && mulValid == 1'b0 && result == '0, "R1 after release", result, 0);
    // R6: behaviour of handshake is covered by the checker; R5 likewise.
    runOp(64'd5,     64'h0000, 0,  64'd23,    0, "len0");
    runOp(64'd7,     64'h0001, 1,  64'd101,   0, "len1one");
    runOp(64'd7,     64'hFFFE, 1,  64'd101,   0, "len1zero");
    runOp(64'd1234,  64'h0000, 16, 64'd40961, 0, "allzero");
    runOp(64'd1234,  64'hFFFF, 16, 64'd40961, 0, "allone");
    runOp(64'd999,   64'hFF05, 5,  64'd65521, 0, "R2 upperbits");
    runOp(64'd2,     64'h0055, 8,  64'd3,     0, "smallmod");
    runOp(64'd0,     64'h00A3, 8,  64'd65535, 0, "zerobase");
    runOp(64'd65534, 64'h8001, 16, 64'd65535, 0, "maxbase");
    runOp(64'd321,   64'h3A5C, 14, 64'd12345, 1, "inject");
    for (int k = 0; k < 24; k++) begin
      n = (64'($urandom) % 64'd65533) | 64'd1;
      if (n < 3) n = 3;
      m = 64'($urandom) % n;
      e = 64'($urandom) & 64'hFFFF;
      h = int'($urandom % (EXP_W + 1));
      runOp(m, e, h, n, (k % 6) == 5, "random");
    end
    finishRun();
  end

endmodule